// File: doc/BRIEF.md
# Audio DMA Channel Status Register

This block holds the status word of one channel of a descriptor-driven audio DMA engine. The channel's sequencer and FIFO report events and conditions through strobes and level signals. The block turns them into a 16-bit status word, and software reads that word through a simple register port. Three of the bits record events and stay set until software writes a one to them. Two bits follow the state of the engine from cycle to cycle. The remaining upper bits are reserved.

One static input chooses between a transmit channel and a receive channel. That choice decides which completion strobe marks the end of the last valid buffer, and which FIFO fault counts as an error. An interrupt request is formed from the three event bits, each gated by its own enable input from the channel's control register. It is registered and stays high until software has cleared every enabled event.

Top module: `audDmaStatus`

## Requirements
- R1: While reset is low and on the first read after it, the status word is 0x0001 (halted) and the interrupt request is 0.
- R2: Status bits 15 to 5 always read 0. Writing to them, to the read-only bits 0 and 1, or writing a 0 to any bit has no effect.
- R3: Bit 0 (halted) is registered. After each clock edge it is 1 if, at that edge, the run input was 0 and the engine-idle input was 1, or if the condition of R4 held. Otherwise it is 0.
- R4: Bit 1 (at last valid buffer) is registered. After each edge it equals index-match AND index-buffer-done AND NOT lvi-write, taken at that edge.
- R5: Bit 2 (last valid buffer done) is set by the last-fetched strobe when the direction input is 0 (transmit), and by the last-written strobe when the direction input is 1 (receive). The strobe that does not belong to the selected direction is ignored.
- R6: Bit 3 (buffer completion) is set when the buffer-done strobe and that buffer's interrupt-on-completion flag are both high in the same cycle. Buffer-done on its own does not set it.
- R7: Bit 4 (FIFO error) is set by an overrun strobe in receive mode or by an underrun strobe in transmit mode, but only while more-valid is 1.
- R8: Bits 2 to 4 stay set until a register write carries a 1 in their position. They read 0 after the edge that takes that write.
- R9: If a set condition and a clearing write hit the same bit at the same edge, the bit ends up set.
- R10: The interrupt request is registered one edge after the status bits. It is 1 when any of bit 2 AND the last-valid enable, bit 3 AND the completion enable, or bit 4 AND the FIFO-error enable held before that edge. It returns to 0 one edge after the last enabled event bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRx | input | 1 | Channel direction: 0 transmit, 1 receive |
| evBufDone | input | 1 | Last sample of a buffer processed (strobe) |
| evBufIoc | input | 1 | Interrupt-on-completion flag of that buffer |
| evLastFetched | input | 1 | Last valid buffer fetched (transmit strobe) |
| evLastWritten | input | 1 | Last valid buffer written to memory (receive strobe) |
| idxMatch | input | 1 | Current index equals last valid index (level) |
| idxBufDone | input | 1 | Buffer at current index processed (level) |
| lviWrite | input | 1 | Software is writing a new last valid index |
| runBit | input | 1 | Run/stop control bit (level) |
| engineIdle | input | 1 | DMA engine has no transfer in flight (level) |
| fifoOverrun | input | 1 | FIFO overrun strobe |
| fifoUnderrun | input | 1 | FIFO underrun strobe |
| moreValid | input | 1 | Further valid buffers remain to process |
| ienIoc | input | 1 | Enable for the completion interrupt (bit 3) |
| ienLvb | input | 1 | Enable for the last-valid interrupt (bit 2) |
| ienFifo | input | 1 | Enable for the FIFO-error interrupt (bit 4) |
| regWrEn | input | 1 | Write strobe for the status word |
| regWrData | input | 16 | Write data; a 1 clears bits 2 to 4 |
| regRdData | output | 16 | Current status word |
| irq | output | 1 | Interrupt request |

## Verification
A sticky bit that is held in the wrong state shows on regRdData right after the next edge. The same fault reaches the irq pin one edge later, but only while its enable is high. For that reason the random phases toggle the enables and compare both outputs in every cycle. An error in the direction select only appears when the other direction's strobe fires, so each direction runs as a separate phase in which strobes from both directions occur. The lost-clear collision and the gap between an event and the interrupt last only one cycle each, so they are driven by directed cases and sampled in the exact cycle they occur.

// File: rtl/audStatPkg.sv
`timescale 1ns/1ps
package audStatPkg;
  localparam int HALT_B = 0;
  localparam int CELV_B = 1;
  localparam int LVB_B  = 2;
  localparam int BC_B   = 3;
  localparam int FE_B   = 4;
  localparam int USED_W = 5;
  localparam int STICKY_N = 3;

  typedef struct packed {
    logic haltNext;
    logic celvNext;
    logic feSet;
    logic bcSet;
    logic lvbSet;
  } statStrb_t;
endpackage

// File: rtl/audStatCtrl.sv
`timescale 1ns/1ps
module audStatCtrl
  import audStatPkg::*;
(
  input  logic      dirRx,
  input  logic      evBufDone,
  input  logic      evBufIoc,
  input  logic      evLastFetched,
  input  logic      evLastWritten,
  input  logic      idxMatch,
  input  logic      idxBufDone,
  input  logic      lviWrite,
  input  logic      runBit,
  input  logic      engineIdle,
  input  logic      fifoOverrun,
  input  logic      fifoUnderrun,
  input  logic      moreValid,
  output statStrb_t strb
);
  logic atLast;
  logic lastEvent;
  logic fifoFault;

  always_comb begin
    atLast    = idxMatch & idxBufDone & ~lviWrite;
    lastEvent = dirRx ? evLastWritten : evLastFetched;
    fifoFault = dirRx ? fifoOverrun : fifoUnderrun;

    strb.celvNext = atLast;
    strb.haltNext = (~runBit & engineIdle) | atLast;
    strb.lvbSet   = lastEvent;
    strb.bcSet    = evBufDone & evBufIoc;
    strb.feSet    = fifoFault & moreValid;
  end
endmodule

// File: rtl/audStatRegs.sv
`timescale 1ns/1ps
module audStatRegs
  import audStatPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  statStrb_t        strb,
  input  logic             ienIoc,
  input  logic             ienLvb,
  input  logic             ienFifo,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irq
);
  localparam int PAD_W = REG_W - USED_W;

  logic                haltQ;
  logic                celvQ;
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] setVec;
  logic [STICKY_N-1:0] clrVec;
  logic [STICKY_N-1:0] enVec;
  logic                irqQ;
  logic                unusedWrBits;

  assign setVec = {strb.feSet, strb.bcSet, strb.lvbSet};
  assign enVec  = {ienFifo, ienIoc, ienLvb};
  assign clrVec = {STICKY_N{regWrEn}} & regWrData[LVB_B +: STICKY_N];
  assign unusedWrBits = ^{regWrData[REG_W-1:USED_W], regWrData[CELV_B:HALT_B]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltQ <= 1'b1;
      celvQ <= 1'b0;
    end else begin
      haltQ <= strb.haltNext;
      celvQ <= strb.celvNext;
    end
  end

  for (genvar i = 0; i < STICKY_N; i++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= (stickyQ[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(stickyQ & enVec);
  end

  assign regRdData = {{PAD_W{1'b0}}, stickyQ, celvQ, haltQ};
  assign irq       = irqQ;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bcSet |=> regRdData[BC_B]);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[FE_B] && !(regWrEn && regWrData[FE_B])) |=> regRdData[FE_B]);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[LVB_B] && !strb.lvbSet) |=> !regRdData[LVB_B]);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[BC_B] && ienIoc) |=> irq);

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[FE_B:LVB_B] == '0) |=> !irq);

  // R4
  celv_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[CELV_B] |-> regRdData[HALT_B]);
endmodule

// File: rtl/audDmaStatus.sv
`timescale 1ns/1ps
module audDmaStatus
  import audStatPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirRx,
  input  logic             evBufDone,
  input  logic             evBufIoc,
  input  logic             evLastFetched,
  input  logic             evLastWritten,
  input  logic             idxMatch,
  input  logic             idxBufDone,
  input  logic             lviWrite,
  input  logic             runBit,
  input  logic             engineIdle,
  input  logic             fifoOverrun,
  input  logic             fifoUnderrun,
  input  logic             moreValid,
  input  logic             ienIoc,
  input  logic             ienLvb,
  input  logic             ienFifo,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irq
);
  statStrb_t strb;

  audStatCtrl uCtrl (
    .dirRx(dirRx), .evBufDone(evBufDone), .evBufIoc(evBufIoc),
    .evLastFetched(evLastFetched), .evLastWritten(evLastWritten),
    .idxMatch(idxMatch), .idxBufDone(idxBufDone), .lviWrite(lviWrite),
    .runBit(runBit), .engineIdle(engineIdle),
    .fifoOverrun(fifoOverrun), .fifoUnderrun(fifoUnderrun),
    .moreValid(moreValid), .strb(strb)
  );

  audStatRegs #(.REG_W(REG_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ienIoc(ienIoc), .ienLvb(ienLvb), .ienFifo(ienFifo),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );
endmodule

// File: tb/audDmaStatus_test.sv
`timescale 1ns/1ps
module audDmaStatus_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirRx = 1'b0, evBufDone = 1'b0, evBufIoc = 1'b0;
  logic evLastFetched = 1'b0, evLastWritten = 1'b0;
  logic idxMatch = 1'b0, idxBufDone = 1'b0, lviWrite = 1'b0;
  logic runBit = 1'b0, engineIdle = 1'b1;
  logic fifoOverrun = 1'b0, fifoUnderrun = 1'b0, moreValid = 1'b0;
  logic ienIoc = 1'b0, ienLvb = 1'b0, ienFifo = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [4:0] mStat = 5'b00001;
  logic mIrq = 1'b0;

  always #2.5 clk = ~clk;

  audDmaStatus uut (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .evBufDone(evBufDone),
    .evBufIoc(evBufIoc), .evLastFetched(evLastFetched),
    .evLastWritten(evLastWritten), .idxMatch(idxMatch),
    .idxBufDone(idxBufDone), .lviWrite(lviWrite), .runBit(runBit),
    .engineIdle(engineIdle), .fifoOverrun(fifoOverrun),
    .fifoUnderrun(fifoUnderrun), .moreValid(moreValid),
    .ienIoc(ienIoc), .ienLvb(ienLvb), .ienFifo(ienFifo),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  function automatic logic [4:0] nextStat(logic [4:0] cur);
    logic [4:0] n;
    logic atLast;
    atLast = idxMatch & idxBufDone & ~lviWrite;
    n[1] = atLast;
    n[0] = (~runBit & engineIdle) | atLast;
    n[2] = (cur[2] & ~(regWrEn & regWrData[2])) | (dirRx ? evLastWritten : evLastFetched);
    n[3] = (cur[3] & ~(regWrEn & regWrData[3])) | (evBufDone & evBufIoc);
    n[4] = (cur[4] & ~(regWrEn & regWrData[4])) |
           (moreValid & (dirRx ? fifoOverrun : fifoUnderrun));
    return n;
  endfunction

  function automatic logic nextIrq(logic [4:0] cur);
    return (cur[2] & ienLvb) | (cur[3] & ienIoc) | (cur[4] & ienFifo);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R3 halted", {15'd0, regRdData[0]}, {15'd0, mStat[0]});
    check("R4 celv",   {15'd0, regRdData[1]}, {15'd0, mStat[1]});
    check("R5 lvb",    {15'd0, regRdData[2]}, {15'd0, mStat[2]});
    check("R6 bcis",   {15'd0, regRdData[3]}, {15'd0, mStat[3]});
    check("R7 fifoe",  {15'd0, regRdData[4]}, {15'd0, mStat[4]});
    check("R2 reserved", {5'd0, regRdData[15:5]}, 16'd0);
    check("R10 irq", {15'd0, irq}, {15'd0, mIrq});
  endtask

  task automatic step();
    logic ni;
    @(posedge clk);
    ni = nextIrq(mStat);
    mStat = nextStat(mStat);
    mIrq = ni;
    @(negedge clk);
    compareAll();
  endtask

  task automatic quiet();
    evBufDone = 0; evBufIoc = 0; evLastFetched = 0; evLastWritten = 0;
    fifoOverrun = 0; fifoUnderrun = 0; lviWrite = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic randomPhase(logic rx, int n);
    dirRx = rx;
    for (int k = 0; k < n; k++) begin
      evBufDone     = ($urandom % 6) == 0;
      evBufIoc      = $urandom % 2;
      evLastFetched = ($urandom % 8) == 0;
      evLastWritten = ($urandom % 8) == 0;
      fifoOverrun   = ($urandom % 8) == 0;
      fifoUnderrun  = ($urandom % 8) == 0;
      moreValid     = $urandom % 2;
      idxMatch      = $urandom % 2;
      idxBufDone    = $urandom % 2;
      lviWrite      = ($urandom % 5) == 0;
      runBit        = $urandom % 2;
      engineIdle    = $urandom % 2;
      if (($urandom % 16) == 0) begin
        ienIoc = $urandom % 2; ienLvb = $urandom % 2; ienFifo = $urandom % 2;
      end
      regWrEn   = ($urandom % 4) == 0;
      regWrData = 16'($urandom);
      step();
    end
    quiet();
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset value while in reset
    check("R1 reset word", regRdData, 16'h0001);
    check("R1 reset irq", {15'd0, irq}, 16'd0);
    rstN = 1'b1;
    step();
    check("R1 first read", regRdData, 16'h0001);

    // R2 writes of ones to reserved and read-only bits, zeros elsewhere
    regWrEn = 1; regWrData = 16'hFFE3; step();
    regWrData = 16'h0000; step();
    check("R2 no effect", regRdData, 16'h0001);
    quiet();

    // R5 transmit: the receive-side strobe is ignored
    dirRx = 0; evLastWritten = 1; step(); quiet();
    check("R5 tx ignores written", regRdData[2] ? 16'd1 : 16'd0, 16'd0);
    evLastFetched = 1; step(); quiet();
    check("R5 tx fetched sets", regRdData[2] ? 16'd1 : 16'd0, 16'd1);

    // R6 buffer done without the completion flag does nothing
    evBufDone = 1; step(); quiet();
    check("R6 no ioc", regRdData[3] ? 16'd1 : 16'd0, 16'd0);

    // R9 set and clear in the same cycle: set wins
    evBufDone = 1; evBufIoc = 1; regWrEn = 1; regWrData = 16'h0008; step(); quiet();
    check("R9 set wins", regRdData[3] ? 16'd1 : 16'd0, 16'd1);

    // R10 irq follows one edge after enabling
    ienIoc = 1; step();
    check("R10 irq raised", {15'd0, irq}, 16'd1);
    // R8 clear bit 3, irq falls one edge later
    regWrEn = 1; regWrData = 16'h0008; step(); quiet();
    check("R8 w1c", regRdData[3] ? 16'd1 : 16'd0, 16'd0);
    check("R10 irq still high", {15'd0, irq}, 16'd1);
    step();
    check("R10 irq dropped", {15'd0, irq}, 16'd0);
    ienIoc = 0;

    // R7 FIFO errors need moreValid; receive needs overrun
    dirRx = 1; moreValid = 0; fifoOverrun = 1; step(); quiet();
    check("R7 no more valid", regRdData[4] ? 16'd1 : 16'd0, 16'd0);
    moreValid = 1; fifoUnderrun = 1; step(); quiet();
    check("R7 rx ignores underrun", regRdData[4] ? 16'd1 : 16'd0, 16'd0);
    fifoOverrun = 1; step(); quiet();
    check("R7 rx overrun", regRdData[4] ? 16'd1 : 16'd0, 16'd1);

    // R4 and R3 live bits; new LVI write drops bit 1
    runBit = 1; engineIdle = 0; idxMatch = 1; idxBufDone = 1; step();
    check("R4 at last", regRdData[1:0], 16'h0003);
    lviWrite = 1; step(); quiet();
    check("R4 lvi write", regRdData[1:0], 16'h0000);
    idxMatch = 0; step();
    check("R3 running", regRdData[1:0], 16'h0000);

    randomPhase(1'b0, 3000);
    randomPhase(1'b1, 3000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule